// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a memory burst. A requester presents a starting column, a two-bit length code and an ordering select, and pulses a start input. From the next clock on, the block puts out one column address per cycle with a valid flag. When the burst ends it drops valid and raises a one-cycle completion flag. Fixed bursts of 2, 4 or 8 beats stay inside the aligned block chosen by the upper column bits. The low bits walk either in ascending order, wrapping inside the block, or in XOR order. A whole-row burst ascends through the row and wraps at the row end. It stops only when the requester asserts a terminate input.

The column width is a parameter, so the row can be 2048, 1024 or 512 columns (11, 10 or 9 bits). Length and ordering are captured when the start is accepted and hold for the whole burst. The control is a four-state machine:
- `ST_IDLE`: waiting for a start.
- `ST_RUN`: emitting beats.
- `ST_FIN`: the one-cycle completion state.
- `ST_REJ`: the one-cycle state that flags a refused start.

The transitions are:
- accept: any state except `ST_RUN` goes to `ST_RUN` on a legal start.
- reject: any state except `ST_RUN` goes to `ST_REJ` on an XOR-order whole-row start.
- finish: `ST_RUN` goes to `ST_FIN` on the last beat.
- settle: `ST_FIN` or `ST_REJ` goes to `ST_IDLE` when no start is present.
- stay: `ST_RUN` remains in `ST_RUN` while beats remain.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_vld_o, busy_o, done_o and err_o are low and col_o is zero.
- R2: A start is accepted when busy_o is low and the start is legal. In the cycle after acceptance, col_o equals the start column, col_vld_o and busy_o are high, and one new beat follows every cycle.
- R3: Length codes 0, 1 and 2 mean 2, 4 and 8 beats (L = 2^k). With ilv_i = 0, the low k bits of beat i are (start low bits + i) mod L, and the upper bits stay equal to the start column's upper bits.
- R4: With ilv_i = 1 and a fixed length, the low k bits of beat i are the start low bits XOR i, and the upper bits are unchanged.
- R5: A fixed burst emits exactly L beats. In the cycle after the last beat, col_vld_o and busy_o are low and done_o is high for one cycle.
- R6: Length code 3 is a whole-row burst. Beat i is (start + i) mod 2^COL_W, so it wraps from the last column to 0 and passes back through the start column.
- R7: In a whole-row burst, a beat during which term_i is high is the last beat, and done_o follows in the next cycle. term_i has no effect on a fixed burst.
- R8: A start with ilv_i = 1 and length code 3 is refused. err_o is high for one cycle, and neither col_vld_o nor busy_o rises.
- R9: While busy_o is high, start_i is ignored. Changes on start_col_i, len_code_i and ilv_i have no effect on the running burst.
- R10: A start is accepted in the cycle in which done_o or err_o is high, giving back-to-back bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 2 | Length code: 0=2, 1=4, 2=8, 3=whole row |
| ilv_i | input | 1 | Ordering: 0 ascending-wrap, 1 XOR order |
| term_i | input | 1 | Ends a whole-row burst after the current beat |
| col_o | output | COL_W | Column of the current beat, zero when not valid |
| col_vld_o | output | 1 | col_o holds a beat |
| busy_o | output | 1 | A burst is running |
| done_o | output | 1 | One-cycle pulse after the last beat |
| err_o | output | 1 | One-cycle pulse on a refused start |

## Verification
If the beat counter or captured base is wrong, col_o leaves its aligned block or breaks the expected order at the first affected beat. That is visible within one cycle of the fault. A state machine that misses its last-beat condition shows at once: valid stays high past beat L, or done_o goes missing in the cycle after it. If start is wrongly accepted mid-burst, the next beat restarts at the new column in the following cycle. The bench compares every beat to an independent model, so these faults are caught in the cycle they appear.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [1:0] {
        LEN2    = 2'd0,
        LEN4    = 2'd1,
        LEN8    = 2'd2,
        LEN_ROW = 2'd3
    } blen_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2,
        ST_REJ  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/burst_col_next.sv
module burst_col_next
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  blen_e            len_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] col_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] low;

    always_comb begin
        unique case (len_i)
            LEN2:    mask_o = ONE;
            LEN4:    mask_o = COL_W'(3);
            LEN8:    mask_o = COL_W'(7);
            LEN_ROW: mask_o = '1;
        endcase
    end

    assign sum   = base_i + idx_i;
    assign low   = ilv_i ? (base_i ^ idx_i) : sum;
    assign col_o = (base_i & ~mask_o) | (low & mask_o);
endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bad_i,
    input  logic last_i,
    output logic load_o,
    output logic adv_o,
    output logic busy_o,
    output logic vld_o,
    output logic done_o,
    output logic err_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (last_i) state_d = ST_FIN;
            ST_IDLE, ST_FIN, ST_REJ: begin
                if (start_i) state_d = bad_i ? ST_REJ : ST_RUN;
                else         state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        adv_o  = 1'b0;
        busy_o = 1'b0;
        vld_o  = 1'b0;
        done_o = 1'b0;
        err_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i && !bad_i;
            ST_RUN: begin
                busy_o = 1'b1;
                vld_o  = 1'b1;
                adv_o  = !last_i;
            end
            ST_FIN: begin
                done_o = 1'b1;
                load_o = start_i && !bad_i;
            end
            ST_REJ: begin
                err_o  = 1'b1;
                load_o = start_i && !bad_i;
            end
        endcase
    end

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_q == ST_RUN)); // R5
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_vld_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    logic [COL_W-1:0] start_r;
    logic [COL_W-1:0] cnt_r;
    blen_e            len_r;
    logic             ilv_r;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] raw_col;
    logic             bad, last, load, adv;

    assign bad  = ilv_i && (len_code_i == 2'd3);
    assign last = (len_r == LEN_ROW) ? term_i : (cnt_r == mask);

    burst_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .bad_i   (bad),
        .last_i  (last),
        .load_o  (load),
        .adv_o   (adv),
        .busy_o  (busy_o),
        .vld_o   (col_vld_o),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_r <= '0;
            cnt_r   <= '0;
            len_r   <= LEN2;
            ilv_r   <= 1'b0;
        end else if (load) begin
            start_r <= start_col_i;
            cnt_r   <= '0;
            len_r   <= blen_e'(len_code_i);
            ilv_r   <= ilv_i;
        end else if (adv) begin
            cnt_r   <= cnt_r + COL_W'(1);
        end
    end

    burst_col_next #(.COL_W(COL_W)) u_next (
        .base_i (start_r),
        .idx_i  (cnt_r),
        .len_i  (len_r),
        .ilv_i  (ilv_r),
        .mask_o (mask),
        .col_o  (raw_col)
    );

    assign col_o = col_vld_o ? raw_col : '0;

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (col_o == $past(start_col_i))); // R2
    AST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld_o && len_r != LEN_ROW) |-> (((col_o ^ start_r) & ~mask) == '0)); // R3
    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld_o && len_r != LEN_ROW) |-> (cnt_r <= mask)); // R5
    AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && bad) |=> (err_o && !col_vld_o)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(start_r)); // R9
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    localparam int CLK_P = 10;
    localparam int COL_W = 11;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [1:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             col_vld_o, busy_o, done_o, err_o;

    int errs = 0;
    int checks = 0;

    always #(CLK_P/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i), .col_o(col_o),
        .col_vld_o(col_vld_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    function automatic int exp_col(int s, int code, bit ilv, int i);
        int len, base, off;
        if (code == 3) return (s + i) % NCOL;
        len  = 2 << code;
        base = s - (s % len);
        off  = s % len;
        return ilv ? base + (off ^ i) : base + ((off + i) % len);
    endfunction

    task automatic kick(int s, int code, bit ilv);
        @(negedge clk);
        start_i = 1'b1; start_col_i = COL_W'(s); len_code_i = 2'(code); ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic fixed_burst(int s, int code, bit ilv, string req);
        kick(s, code, ilv);
        for (int i = 0; i < (2 << code); i++) begin
            chk({req, " col"}, int'(col_o), exp_col(s, code, ilv, i));
            chk("R2 vld", int'(col_vld_o), 1);
            @(negedge clk);
        end
        chk("R5 done", int'(done_o), 1);
        chk("R5 vld low", int'(col_vld_o), 0);
        @(negedge clk);
        chk("R5 done pulse", int'(done_o), 0);
    endtask

    task automatic t_reset();
        chk("R1 vld", int'(col_vld_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 col", int'(col_o), 0);
    endtask

    task automatic t_ignore();
        kick(21, 2, 1'b0);
        for (int i = 0; i < 8; i++) begin
            chk("R9 col", int'(col_o), exp_col(21, 2, 0, i));
            chk("R9 err", int'(err_o), 0);
            start_i = (i == 2); ilv_i = 1'b1; len_code_i = 2'd3;
            start_col_i = COL_W'(300); term_i = (i == 3); // R7 term ignored on fixed
            @(negedge clk);
            start_i = 1'b0; term_i = 1'b0;
        end
        chk("R7 fixed length kept", int'(done_o), 1);
        @(negedge clk);
    endtask

    task automatic t_row(int s, int nbeats);
        kick(s, 3, 1'b0);
        for (int i = 0; i < nbeats; i++) begin
            chk("R6 col", int'(col_o), exp_col(s, 3, 0, i));
            term_i = (i == nbeats - 1);
            @(negedge clk);
        end
        term_i = 1'b0;
        chk("R7 done after term", int'(done_o), 1);
        chk("R7 vld low", int'(col_vld_o), 0);
        @(negedge clk);
    endtask

    task automatic t_err_b2b();
        kick(5, 3, 1'b1);
        chk("R8 err", int'(err_o), 1);
        chk("R8 vld", int'(col_vld_o), 0);
        chk("R8 busy", int'(busy_o), 0);
        start_i = 1'b1; start_col_i = COL_W'(4); len_code_i = 2'd0; ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 after err", int'(col_o), 4);
        @(negedge clk);
        chk("R10 beat1", int'(col_o), 5);
        @(negedge clk);
        chk("R10 done", int'(done_o), 1);
        start_i = 1'b1; start_col_i = COL_W'(9); len_code_i = 2'd1; ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R10 after done", int'(col_o), exp_col(9, 1, 0, i));
            @(negedge clk);
        end
        chk("R10 second done", int'(done_o), 1);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        fixed_burst(0, 0, 1'b0, "R3 L2");
        fixed_burst(7, 1, 1'b0, "R3 L4");
        fixed_burst(13, 2, 1'b0, "R3 L8");
        fixed_burst(1027, 0, 1'b1, "R4 L2");
        fixed_burst(6, 1, 1'b1, "R4 L4");
        fixed_burst(42, 2, 1'b1, "R4 L8");
        t_ignore();
        t_row(NCOL - 3, 6);
        t_row(7, NCOL + 2);
        t_err_b2b();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule